// File: doc/BRIEF.md
# Down-Counting Interval Timer

A single down-counter with a small word-addressed register file. Software writes a start value and picks one-shot, periodic or free-running operation. The counter then decrements on qualified ticks of `tick_en`, divided by a selectable prescaler. It raises a status flag each time it reaches zero. The flag is visible unmasked in a status word and drives `irq` through an enable bit. Writing to the clear word drops the flag.

There are two ways to set the count. A write to the start word loads the counter and the reload value together. A write to the shadow word changes only the reload value that the next wrap will use, so a running period can be retuned without a glitch. The counter works at full width or on its low half only.

Top module: `ivtimer`

## Requirements
- R1: After reset the value word (byte 0x04) reads 0xFFFFFFFF, and the control word, the raw status and `irq` are all 0.
- R2: A write to byte 0x00 sets both the live count and the reload value to the written data, as seen on the next cycle. It also restarts the prescaler and takes priority over a count step in the same cycle.
- R3: A write to byte 0x18 changes only the reload value, and the live count keeps its course. The reload value reads back at both 0x00 and 0x18.
- R4: The count moves only when control bit 7 is 1 and `tick_en` is high. Each qualified step lowers it by one.
- R5: Control bits 3:2 select the tick divider: 00 is /1, 01 is /16, 10 is /256, and 11 is /1.
- R6: A step that takes the count from 1 to 0 sets the raw flag. With control bit 0 set (one-shot), the count then stays at 0.
- R7: In continuous mode (bit 0 clear), a step taken at zero reloads the counter. With bit 6 set it loads the reload value; with bit 6 clear it loads all ones of the active width.
- R8: With control bit 1 clear, only bits 15:0 count and are tested for zero, and bits 31:16 are left alone. A reload in this mode loads the low half and zeroes the upper half.
- R9: A write of any data to byte 0x0C clears the raw flag. A zero-crossing in the same cycle wins, and the flag stays set.
- R10: Byte 0x10 bit 0 reads the raw flag whatever the enable. `irq` and byte 0x14 bit 0 equal the raw flag ANDed with control bit 5.
- R11: The control word reads at 0x08 with bits 31:8 as zero. Unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 5 | Byte offset of the register |
| wdata | input | 32 | Write data |
| wr_en | input | 1 | Write strobe |
| tick_en | input | 1 | Count-enable tick |
| rdata | output | 32 | Combinational read data |
| irq | output | 1 | Masked interrupt |

## Verification
A behavioural model in the bench tracks the count, the reload value, the prescaler phase and the flag, and the bench compares `rdata` and `irq` with it on every clock. Directed sequences cover the following:
- Loads with ticks held low, which separate the immediate start path from the shadow path.
- Runs of ticks under each divider code, which expose a wrong division ratio.
- One-shot, periodic and free-running wraps, which tell the three reload sources apart.
- A half-width count with nonzero upper bits, which shows whether the zero test and the reload are confined to the low half.
- A clear written in the very cycle of a zero-crossing, which checks the priority.

// File: rtl/ivtimer.sv
module ivtimer #(
  parameter int CW    = 32,
  parameter int AW    = 5,
  parameter int PRE_W = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic [CW-1:0] wdata,
  input  logic          wr_en,
  input  logic          tick_en,
  output logic [CW-1:0] rdata,
  output logic          irq
);
  localparam int HW = CW / 2;

  logic [CW-1:0]    cnt, rel;
  logic [7:0]       ctrl;
  logic [PRE_W-1:0] pre;
  logic             raw;

  wire sel_ld  = wr_en && addr[AW-1:2] == 3'd0;
  wire sel_ctl = wr_en && addr[AW-1:2] == 3'd2;
  wire sel_clr = wr_en && addr[AW-1:2] == 3'd3;
  wire sel_bg  = wr_en && addr[AW-1:2] == 3'd6;

  wire one_shot = ctrl[0];
  wire wide     = ctrl[1];
  wire periodic = ctrl[6];
  wire run      = ctrl[7] && tick_en;

  logic pre_hit;
  always_comb begin
    case (ctrl[3:2])
      2'b01:   pre_hit = &pre[3:0];
      2'b10:   pre_hit = &pre;
      default: pre_hit = 1'b1;
    endcase
  end

  wire step    = run && pre_hit && !sel_ld;
  wire at_zero = wide ? (cnt == '0) : (cnt[HW-1:0] == '0);
  wire at_one  = wide ? (cnt == CW'(1)) : (cnt[HW-1:0] == HW'(1));
  wire event_z = step && at_one;

  logic [CW-1:0] wrap_val, next_dn;
  always_comb begin
    if (periodic) wrap_val = wide ? rel : {{HW{1'b0}}, rel[HW-1:0]};
    else          wrap_val = wide ? {CW{1'b1}} : {{HW{1'b0}}, {HW{1'b1}}};
    next_dn = wide ? cnt - 1'b1 : {cnt[CW-1:HW], cnt[HW-1:0] - 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '1;
      rel <= '0;
      pre <= '0;
    end else if (sel_ld) begin
      cnt <= wdata;
      rel <= wdata;
      pre <= '0;
    end else begin
      if (sel_bg) rel <= wdata;
      if (sel_ctl) pre <= '0;
      else if (run) pre <= pre + 1'b1;
      if (step) begin
        if (!at_zero) cnt <= next_dn;
        else if (!one_shot) cnt <= wrap_val;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl <= '0;
    else if (sel_ctl) ctrl <= wdata[7:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) raw <= 1'b0;
    else if (event_z) raw <= 1'b1;
    else if (sel_clr) raw <= 1'b0;
  end

  assign irq = raw && ctrl[5];

  always_comb begin
    case (addr[AW-1:2])
      3'd0, 3'd6: rdata = rel;
      3'd1:       rdata = cnt;
      3'd2:       rdata = {{(CW-8){1'b0}}, ctrl};
      3'd4:       rdata = {{(CW-1){1'b0}}, raw};
      3'd5:       rdata = {{(CW-1){1'b0}}, irq};
      default:    rdata = '0;
    endcase
  end

  p_load_now_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sel_ld |=> (cnt == $past(wdata) && rel == $past(wdata)));
  p_bg_keeps_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_bg && !step) |=> (cnt == $past(cnt) && rel == $past(wdata)));
  p_idle_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !sel_ld) |=> $stable(cnt));
  p_oneshot_stays_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (one_shot && at_zero && !sel_ld) |=> $stable(cnt));
  p_zero_sets_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    event_z |=> raw);
  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_clr && !event_z) |=> !raw);
  p_mask_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl[5] |-> !irq);
endmodule

// File: tb/sim_ivtimer.sv
module sim_ivtimer;
  logic        clk = 0, rst_n = 0;
  logic [4:0]  addr = 0;
  logic [31:0] wdata = 0;
  logic        wr_en = 0, tick_en = 0;
  logic [31:0] rdata;
  logic        irq;
  int checks = 0, fails = 0;
  string cur_req = "R1";

  always #10 clk = ~clk;

  ivtimer u0 (.clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en),
              .tick_en(tick_en), .rdata(rdata), .irq(irq));

  // behavioural reference
  longint unsigned m_cnt, m_rel;
  int m_ctrl, m_div_phase;
  bit m_raw;

  function automatic int divider(int c);
    case ((c >> 2) & 3)
      1: return 16;
      2: return 256;
      default: return 1;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 32'hFFFFFFFF; m_rel = 0; m_ctrl = 0; m_div_phase = 0; m_raw = 0;
    end else begin
      bit stepping, hit;
      longint unsigned modulus, low;
      stepping = 0; hit = 0;
      if (wr_en && addr == 5'h00) begin
        m_cnt = wdata; m_rel = wdata; m_div_phase = 0;
      end else begin
        if ((m_ctrl & 8'h80) && tick_en) begin
          m_div_phase++;
          if (m_div_phase % divider(m_ctrl) == 0) stepping = 1;
          if (m_div_phase >= 256) m_div_phase = 0;
        end
        if (stepping) begin
          modulus = (m_ctrl & 2) ? 64'h1_0000_0000 : 64'h1_0000;
          low = m_cnt % modulus;
          if (low == 1) hit = 1;
          if (low != 0) m_cnt = m_cnt - 1;
          else if (!(m_ctrl & 1)) begin
            if (m_ctrl & 8'h40) m_cnt = m_rel % modulus;
            else m_cnt = modulus - 1;
          end
        end
        if (wr_en && addr == 5'h18) m_rel = wdata;
        if (wr_en && addr == 5'h08) begin m_ctrl = wdata & 8'hFF; m_div_phase = 0; end
      end
      if (hit) m_raw = 1;
      else if (wr_en && addr == 5'h0C) m_raw = 0;
    end
  end

  function automatic logic [31:0] m_read(logic [4:0] a);
    case (a[4:2])
      0, 6: return m_rel[31:0];
      1: return m_cnt[31:0];
      2: return m_ctrl;
      4: return m_raw;
      5: return m_raw && (m_ctrl & 8'h20);
      default: return 0;
    endcase
  endfunction

  always @(negedge clk) if (rst_n) begin
    checks++;
    if (rdata !== m_read(addr)) begin
      fails++; $display("FAIL %s rdata@%h actual=%h expected=%h", cur_req, addr, rdata, m_read(addr));
    end
    checks++;
    if (irq !== (m_raw && (m_ctrl & 8'h20) != 0)) begin
      fails++; $display("FAIL R10 irq actual=%b expected=%b", irq, m_raw && (m_ctrl & 8'h20) != 0);
    end
  end

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1;
    @(negedge clk); wr_en = 0; addr = 5'h04;
  endtask

  task automatic ticks(input int n);
    @(negedge clk); tick_en = 1;
    repeat (n) @(negedge clk);
    tick_en = 0;
  endtask

  task automatic expect_rd(input string req, input logic [4:0] a, input logic [31:0] e);
    addr = a; #1;
    checks++;
    if (rdata !== e) begin
      fails++; $display("FAIL %s read@%h actual=%h expected=%h", req, a, rdata, e);
    end
  endtask

  initial begin
    #5000000;
    fails++; $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk); rst_n = 1; addr = 5'h04;
    @(negedge clk);
    expect_rd("R1", 5'h04, 32'hFFFFFFFF);
    expect_rd("R1", 5'h08, 0);
    expect_rd("R1", 5'h10, 0);
    checks++; if (irq !== 0) begin fails++; $display("FAIL R1 irq actual=%b expected=0", irq); end

    cur_req = "R2"; wr(5'h00, 5); expect_rd("R2", 5'h04, 5);
    cur_req = "R3"; wr(5'h18, 9); expect_rd("R3", 5'h04, 5); expect_rd("R3", 5'h00, 9);
    expect_rd("R11", 5'h1C, 0);

    cur_req = "R4"; wr(5'h08, 32'hFFFF_FF02); expect_rd("R11", 5'h08, 32'h02);
    wr(5'h00, 7); ticks(5); expect_rd("R4", 5'h04, 7);
    wr(5'h08, 32'h82); repeat (4) @(negedge clk); expect_rd("R4", 5'h04, 7);
    ticks(3); expect_rd("R4", 5'h04, 4);

    cur_req = "R5"; wr(5'h08, 32'h86); wr(5'h00, 100); ticks(32); expect_rd("R5", 5'h04, 98);
    wr(5'h08, 32'h8A); wr(5'h00, 100); ticks(512); expect_rd("R5", 5'h04, 98);
    wr(5'h08, 32'h8E); wr(5'h00, 100); ticks(5); expect_rd("R5", 5'h04, 95);

    cur_req = "R6"; wr(5'h08, 32'h83); wr(5'h00, 3); ticks(10);
    expect_rd("R6", 5'h04, 0); expect_rd("R10", 5'h10, 1); expect_rd("R10", 5'h14, 0);
    checks++; if (irq !== 0) begin fails++; $display("FAIL R10 masked irq actual=%b expected=0", irq); end
    wr(5'h08, 32'hA3); expect_rd("R10", 5'h14, 1);
    cur_req = "R9"; wr(5'h0C, 32'h1234); expect_rd("R9", 5'h10, 0);

    cur_req = "R7"; wr(5'h08, 32'hE2); wr(5'h00, 2); ticks(3); expect_rd("R7", 5'h04, 2);
    wr(5'h18, 4); ticks(3); expect_rd("R7", 5'h04, 4);
    wr(5'h08, 32'h82); wr(5'h00, 1); ticks(2); expect_rd("R7", 5'h04, 32'hFFFFFFFF);

    cur_req = "R8"; wr(5'h0C, 0); wr(5'h08, 32'h80); wr(5'h00, 32'h0001_0001);
    ticks(1); expect_rd("R8", 5'h04, 32'h0001_0000); expect_rd("R8", 5'h10, 1);
    ticks(1); expect_rd("R8", 5'h04, 32'h0000_FFFF);

    cur_req = "R9"; wr(5'h08, 32'hA3); wr(5'h00, 1);
    @(negedge clk); addr = 5'h0C; wdata = 0; wr_en = 1; tick_en = 1;
    @(negedge clk); wr_en = 0; tick_en = 0;
    expect_rd("R9", 5'h10, 1);
    @(negedge clk); addr = 5'h0C; wr_en = 1; tick_en = 1;
    @(negedge clk); wr_en = 0; tick_en = 0;
    expect_rd("R9", 5'h10, 0);

    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule